// File: doc/BRIEF.md
# Two-Path Echo Channel Emulator

This block emulates a two-ray propagation channel on a stream of signed real samples. Each accepted input sample leaves the block as itself plus an echo. The echo is a delayed copy of the input, filtered by a short FIR. The echo delay has two parts. A whole-sample offset of 0 to 15 samples is taken from a history register chain. The sub-sample part comes from the FIR taps, which host software computes and writes in at runtime. Together these place the echo anywhere from zero to beyond twelve samples behind the direct path, in fine steps.

Samples enter and leave on valid/ready streams, one per clock at full rate. The pipeline stalls as a whole. When the output holds a sample that the sink has not taken, everything freezes, including the output data, and `in_ready` drops in that same cycle. `in_ready` is `!out_valid || out_ready`, so it depends combinationally on `out_ready`. The echo delay counts accepted samples, so idle cycles on the input do not stretch it.

Configuration is written through a plain register port into a staging copy. A one-cycle commit pulse moves the whole staging copy into the working set on one clock edge. A filter made partly of old taps and partly of new ones is therefore never used.

Top module: `twopath_echo_emu`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every working tap, the offset and the mode are zero. The sample history reads as zero, so the first outputs equal the input samples.
- R2: For accepted sample x[n], the output is sat(x[n] + e[n]), where e[n] = floor((A + 2^14) / 2^15) and A = sum over k of c_k * x[n-D-k]. The taps c_k are signed Q1.15, D is the working offset, and samples from before reset count as 0.
- R3: With `out_ready` held high, the result for a sample accepted at clock edge t appears with `out_valid` high just after edge t+3. That is a latency of four edges.
- R4: Input cycles with `in_valid` low do not advance the history, so D and k count accepted samples only.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_data` keep their values at the next edge.
- R6: A write at `cfg_addr` 0 to 6 loads staging tap k = address. A write at address 7 loads the offset from bits [3:0] and the short mode from bit 4. Writes change no output until a commit.
- R7: A commit pulse copies the whole staging set into the working set. A sample accepted in the same cycle as the commit, or earlier, uses the old set. Every later sample uses the new set. A write issued in the commit cycle lands in staging only.
- R8: In short mode, taps 3 to 6 are treated as zero whatever they hold, which leaves a 3-tap filter.
- R9: An output sum outside the signed 16-bit range clamps to 32767 or to -32768. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts the input this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Sink takes the output this cycle |
| out_data | output | 16 | Signed, saturated direct-plus-echo sample |
| cfg_wr_en | input | 1 | Staging register write strobe |
| cfg_addr | input | 3 | 0 to 6: tap index; 7: offset and mode |
| cfg_wr_data | input | 16 | Tap value (Q1.15), or {mode bit 4, offset bits 3:0} |
| cfg_commit | input | 1 | Copy staging set to working set |

## Verification
The bench sweeps every offset from 0 to 15 in both the 7-tap and the 3-tap mode. For each setting it streams a lone impulse followed by a ramp. The impulse shows each tap alone at its own distance, which separates an offset error from a tap-order error. The ramp checks that the products are summed and rounded correctly. Full-scale inputs of both signs, combined with taps near +1 and at exactly -1, drive the sum past both rails. A stream with idle input cycles and a stalling sink shows whether the echo distance counts samples rather than clocks, and whether the output holds while stalled. Two further streams exercise configuration. One writes staging without committing, which tells leaking writes apart from a correct commit. The other commits in the middle of a continuous stream, which shows exactly which sample first uses the new set.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  typedef enum logic {
    TAPS_FULL  = 1'b0,
    TAPS_SHORT = 1'b1
  } tap_mode_e;
endpackage

// File: rtl/tpe_cfg_bank.sv
module tpe_cfg_bank
  import tpe_pkg::*;
#(
  parameter int NUM_TAPS = 7,
  parameter int COEF_W   = 16,
  parameter int DSEL_W   = 4,
  parameter int ADDR_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [COEF_W-1:0]                wr_data,
  input  logic                             commit,
  output logic [NUM_TAPS-1:0][COEF_W-1:0]  act_coef,
  output logic [DSEL_W-1:0]                act_dsel,
  output tap_mode_e                        act_mode
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_TAPS);

  logic [NUM_TAPS-1:0][COEF_W-1:0] shd_coef;
  logic [DSEL_W-1:0]               shd_dsel;
  tap_mode_e                       shd_mode;

  // staging copy, written one word at a time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_coef <= '0;
      shd_dsel <= '0;
      shd_mode <= TAPS_FULL;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_TAPS; k++) begin
        if (wr_addr == ADDR_W'(k)) shd_coef[k] <= wr_data;
      end
      if (wr_addr == CTRL_ADDR) begin
        shd_dsel <= wr_data[DSEL_W-1:0];
        shd_mode <= tap_mode_e'(wr_data[DSEL_W]);
      end
    end
  end

  // working copy, swapped as a whole
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_coef <= '0;
      act_dsel <= '0;
      act_mode <= TAPS_FULL;
    end else if (commit) begin
      act_coef <= shd_coef;
      act_dsel <= shd_dsel;
      act_mode <= shd_mode;
    end
  end

  AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_coef == $past(shd_coef)) && (act_dsel == $past(shd_dsel))); // R7
  AST_STAGING_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_coef) && $stable(act_dsel) && $stable(act_mode)); // R6
endmodule

// File: rtl/tpe_tap_window.sv
module tpe_tap_window
  import tpe_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 16,
  parameter int NUM_TAPS   = 7,
  parameter int SHORT_TAPS = 3,
  parameter int DSEL_W     = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               adv,
  input  logic                               in_valid,
  input  logic [SAMPLE_W-1:0]                in_data,
  input  logic [NUM_TAPS-1:0][COEF_W-1:0]    act_coef,
  input  logic [DSEL_W-1:0]                  act_dsel,
  input  tap_mode_e                          act_mode,
  output logic                               a_valid,
  output logic [SAMPLE_W-1:0]                a_direct,
  output logic [NUM_TAPS-1:0][SAMPLE_W-1:0]  a_win,
  output logic [NUM_TAPS-1:0][COEF_W-1:0]    a_coef
);
  // older samples needed: largest offset plus the span of the taps
  localparam int HIST_LEN = (1 << DSEL_W) - 1 + NUM_TAPS - 1;

  logic [SAMPLE_W-1:0]               hist [HIST_LEN];
  logic [NUM_TAPS-1:0][SAMPLE_W-1:0] win_n;
  logic [NUM_TAPS-1:0][COEF_W-1:0]   coef_n;
  logic                              take;

  assign take = adv && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST_LEN; i++) hist[i] <= '0;
    end else if (take) begin
      hist[0] <= in_data;
      for (int i = 1; i < HIST_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  // tap k reads the sample D+k places back; place 0 is the arriving sample
  always_comb begin
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (int'(act_dsel) + k == 0) win_n[k] = in_data;
      else                         win_n[k] = hist[int'(act_dsel) + k - 1];
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (act_mode == TAPS_SHORT && k >= SHORT_TAPS) coef_n[k] = '0;
      else                                           coef_n[k] = act_coef[k];
    end
  end

  // operands travel with their sample, so a commit never splits a filter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid  <= 1'b0;
      a_direct <= '0;
      a_win    <= '0;
      a_coef   <= '0;
    end else if (adv) begin
      a_valid <= in_valid;
      if (in_valid) begin
        a_direct <= in_data;
        a_win    <= win_n;
        a_coef   <= coef_n;
      end
    end
  end

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(hist[0]) && $stable(hist[HIST_LEN-1])); // R4

  generate
    if (NUM_TAPS > SHORT_TAPS) begin : g_short_chk
      AST_SHORT_TAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        take && act_mode == TAPS_SHORT |=> a_coef[NUM_TAPS-1] == '0); // R8
    end
  endgenerate
endmodule

// File: rtl/tpe_fir.sv
module tpe_fir #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int NUM_TAPS = 7,
  parameter int ECHO_W   = 20
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               adv,
  input  logic                               a_valid,
  input  logic [SAMPLE_W-1:0]                a_direct,
  input  logic [NUM_TAPS-1:0][SAMPLE_W-1:0]  a_win,
  input  logic [NUM_TAPS-1:0][COEF_W-1:0]    a_coef,
  output logic                               c_valid,
  output logic [SAMPLE_W-1:0]                c_direct,
  output logic signed [ECHO_W-1:0]           c_echo
);
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int ACC_W  = ECHO_W + COEF_W - 1;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (COEF_W - 2);

  logic signed [PROD_W-1:0] prod [NUM_TAPS];
  logic                     b_valid;
  logic [SAMPLE_W-1:0]      b_direct;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  acc_rnd;

  // stage B: one registered product per tap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_valid  <= 1'b0;
      b_direct <= '0;
      for (int k = 0; k < NUM_TAPS; k++) prod[k] <= '0;
    end else if (adv) begin
      b_valid <= a_valid;
      if (a_valid) begin
        b_direct <= a_direct;
        for (int k = 0; k < NUM_TAPS; k++)
          prod[k] <= $signed(a_win[k]) * $signed(a_coef[k]);
      end
    end
  end

  // full-precision sum, then round half up at the Q1.15 point
  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TAPS; k++)
      acc = acc + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    acc_rnd = acc + HALF_LSB;
  end

  // stage C
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_valid  <= 1'b0;
      c_direct <= '0;
      c_echo   <= '0;
    end else if (adv) begin
      c_valid <= b_valid;
      if (b_valid) begin
        c_direct <= b_direct;
        c_echo   <= ECHO_W'(acc_rnd >>> (COEF_W - 1));
      end
    end
  end

  AST_FIR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(c_echo) && $stable(c_valid) && $stable(b_valid)); // R5
endmodule

// File: rtl/tpe_sum_sat.sv
module tpe_sum_sat #(
  parameter int SAMPLE_W = 16,
  parameter int ECHO_W   = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      c_valid,
  input  logic [SAMPLE_W-1:0]       c_direct,
  input  logic signed [ECHO_W-1:0]  c_echo,
  output logic                      d_valid,
  output logic [SAMPLE_W-1:0]       d_data
);
  localparam int SUM_W = ECHO_W + 1;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(1 << (SAMPLE_W - 1));

  logic signed [SUM_W-1:0]    wide;
  logic        [SAMPLE_W-1:0] clamped;

  always_comb begin
    wide = {{(SUM_W-SAMPLE_W){c_direct[SAMPLE_W-1]}}, c_direct}
         + {c_echo[ECHO_W-1], c_echo};
    if (wide > MAX_V)      clamped = {1'b0, {(SAMPLE_W-1){1'b1}}};
    else if (wide < MIN_V) clamped = {1'b1, {(SAMPLE_W-1){1'b0}}};
    else                   clamped = SAMPLE_W'(wide);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_data  <= '0;
    end else if (adv) begin
      d_valid <= c_valid;
      if (c_valid) d_data <= clamped;
    end
  end

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    adv && c_valid && (wide > MAX_V) |=> d_data == SAMPLE_W'(MAX_V)); // R9
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    adv && c_valid && (wide < MIN_V) |=> d_data == SAMPLE_W'(MIN_V)); // R9
endmodule

// File: rtl/twopath_echo_emu.sv
module twopath_echo_emu
  import tpe_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 16,
  parameter int NUM_TAPS   = 7,
  parameter int SHORT_TAPS = 3,
  parameter int DSEL_W     = 4,
  parameter int ADDR_W     = $clog2(NUM_TAPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SAMPLE_W-1:0]  in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SAMPLE_W-1:0]  out_data,
  input  logic                 cfg_wr_en,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [COEF_W-1:0]    cfg_wr_data,
  input  logic                 cfg_commit
);
  localparam int ECHO_W = SAMPLE_W + 1 + $clog2(NUM_TAPS);

  logic                              adv;
  logic [NUM_TAPS-1:0][COEF_W-1:0]   act_coef;
  logic [DSEL_W-1:0]                 act_dsel;
  tap_mode_e                         act_mode;
  logic                              a_valid;
  logic [SAMPLE_W-1:0]               a_direct;
  logic [NUM_TAPS-1:0][SAMPLE_W-1:0] a_win;
  logic [NUM_TAPS-1:0][COEF_W-1:0]   a_coef;
  logic                              c_valid;
  logic [SAMPLE_W-1:0]               c_direct;
  logic signed [ECHO_W-1:0]          c_echo;

  // whole pipeline moves together unless the sink refuses a held sample
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  tpe_cfg_bank #(
    .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .DSEL_W(DSEL_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wr_data), .commit(cfg_commit),
    .act_coef(act_coef), .act_dsel(act_dsel), .act_mode(act_mode)
  );

  tpe_tap_window #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .NUM_TAPS(NUM_TAPS),
    .SHORT_TAPS(SHORT_TAPS), .DSEL_W(DSEL_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid), .in_data(in_data),
    .act_coef(act_coef), .act_dsel(act_dsel), .act_mode(act_mode),
    .a_valid(a_valid), .a_direct(a_direct), .a_win(a_win), .a_coef(a_coef)
  );

  tpe_fir #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .NUM_TAPS(NUM_TAPS), .ECHO_W(ECHO_W)
  ) u_fir (
    .clk(clk), .rst_n(rst_n), .adv(adv), .a_valid(a_valid), .a_direct(a_direct),
    .a_win(a_win), .a_coef(a_coef),
    .c_valid(c_valid), .c_direct(c_direct), .c_echo(c_echo)
  );

  tpe_sum_sat #(
    .SAMPLE_W(SAMPLE_W), .ECHO_W(ECHO_W)
  ) u_sum (
    .clk(clk), .rst_n(rst_n), .adv(adv), .c_valid(c_valid), .c_direct(c_direct),
    .c_echo(c_echo), .d_valid(out_valid), .d_data(out_data)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
endmodule

// File: tb/twopath_echo_emu_tb.sv
module twopath_echo_emu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wr_data = '0;
  logic        cfg_commit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twopath_echo_emu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wr_data(cfg_wr_data), .cfg_commit(cfg_commit)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int    m_shd_c [7];
  int    m_act_c [7];
  int    m_shd_d = 0, m_act_d = 0, m_shd_s = 0, m_act_s = 0;
  int    xs [$];
  int    exp_q [$];
  string tag_q [$];
  string cur_tag = "R1";
  int    cfg_c [7];
  int    step_no = 0, first_acc = -1, first_ov = -1;
  bit    stall_prev = 0;
  int    held = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_out(input int n);
    longint acc = 0;
    longint echo;
    int ntap = (m_act_s != 0) ? 3 : 7;
    int s;
    for (int k = 0; k < ntap; k++) begin
      int idx = n - m_act_d - k;
      if (idx >= 0) acc += longint'(m_act_c[k]) * longint'(xs[idx]);
    end
    echo = (acc + 64'sd16384) >>> 15;
    s = xs[n] + int'(echo);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic step(input bit iv, input int idata, input bit ordy,
                      input bit wen, input int waddr, input int wdata, input bit cmt);
    @(negedge clk);
    in_valid = iv; in_data = 16'(idata); out_ready = ordy;
    cfg_wr_en = wen; cfg_addr = 3'(waddr); cfg_wr_data = 16'(wdata); cfg_commit = cmt;
    #1;
    step_no++;
    if (stall_prev) begin
      check("R5 hold valid", int'(out_valid), 1);
      check("R5 hold data", int'($signed(out_data)), held);
    end
    if (out_valid && !out_ready) check("R5 ready low", int'(in_ready), 0);
    if (out_valid && first_ov < 0) first_ov = step_no;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R2 unexpected output", 1, 0);
      else begin
        int e = exp_q.pop_front();
        string t = tag_q.pop_front();
        check(t, int'($signed(out_data)), e);
      end
    end
    if (iv && in_ready) begin
      xs.push_back(int'($signed(16'(idata))));
      exp_q.push_back(model_out(xs.size() - 1));
      tag_q.push_back(cur_tag);
      if (first_acc < 0) first_acc = step_no;
    end
    stall_prev = out_valid && !out_ready;
    held = int'($signed(out_data));
    if (cmt) begin
      for (int k = 0; k < 7; k++) m_act_c[k] = m_shd_c[k];
      m_act_d = m_shd_d; m_act_s = m_shd_s;
    end
    if (wen) begin
      if (waddr < 7) m_shd_c[waddr] = int'($signed(16'(wdata)));
      else begin m_shd_d = wdata & 15; m_shd_s = (wdata >> 4) & 1; end
    end
  endtask

  task automatic send(input int v);
    step(1, v, 1, 0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 30 && exp_q.size() > 0; i++) step(0, 0, 1, 0, 0, 0, 0);
    check("R2 drain empty", exp_q.size(), 0);
  endtask

  task automatic write_set(input int dsel, input int shortm, input bit do_commit);
    for (int k = 0; k < 7; k++) step(0, 0, 1, 1, k, cfg_c[k], 0);
    step(0, 0, 1, 1, 7, dsel | (shortm << 4), 0);
    if (do_commit) step(0, 0, 1, 0, 0, 0, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 7; k++) begin m_shd_c[k] = 0; m_act_c[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R1/R3: zero taps pass samples straight through; latency measured
    cur_tag = "R1";
    for (int i = 0; i < 8; i++) send(i * 3001 - 11000);
    check("R3 latency", first_ov - first_acc, 4);
    drain();

    // R2/R8: every offset, both tap modes, impulse then ramp
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 16; d++) begin
        for (int k = 0; k < 7; k++)
          cfg_c[k] = ((k % 2) ? -1 : 1) * (2000 + 1700 * k + 53 * d);
        write_set(d, m, 1);
        cur_tag = (m == 0) ? "R2 full" : "R8 short";
        send(12000);
        for (int i = 0; i < d + 8; i++) send(0);
        for (int r = 0; r < 6; r++) send(r * 5011 - 12000);
        drain();
      end
    end

    // R9: taps near +1 and exactly -1 push past both rails
    cur_tag = "R9";
    for (int k = 0; k < 7; k++) cfg_c[k] = 0;
    cfg_c[0] = 32767;
    write_set(0, 0, 1);
    send(30000); send(-30000); send(32767); send(-32768); send(100); send(16000);
    drain();
    cfg_c[0] = -32768; cfg_c[1] = 32767;
    write_set(0, 0, 1);
    send(-32768); send(-32768); send(32767); send(-20000); send(25000); send(0);
    drain();

    // R4/R5: idle input cycles and a stalling sink
    cur_tag = "R4";
    for (int k = 0; k < 7; k++) cfg_c[k] = 3000 * (k + 1) - 9000;
    write_set(3, 0, 1);
    for (int i = 0; i < 48; i++)
      step((i % 3) != 1, i * 997 - 20000, (i % 4) != 2, 0, 0, 0, 0);
    drain();

    // R6: staging writes without a commit leave the output on the old set
    cur_tag = "R6";
    for (int k = 0; k < 7; k++) cfg_c[k] = 20000 - 5000 * k;
    write_set(9, 0, 0);
    for (int i = 0; i < 14; i++) send(i * 2100 - 13000);
    drain();

    // R7: commit in mid-stream on the same cycle as an accepted sample
    cur_tag = "R7";
    for (int i = 0; i < 24; i++)
      step(1, 9000 - i * 811, 1, 0, 0, 0, i == 10);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule